// File: doc/BRIEF.md
# Timer Output Compare Unit

The block compares a free-running timer count against two programmable values and drives one output pin together with a one-cycle interrupt strobe. A 3-bit mode input selects the pin behaviour:

- a disabled state in which the pin follows a fallback level;
- two single-shot edge modes;
- a toggle mode;
- a delayed single pulse;
- a pulse that repeats each timer period;
- pulse-width modulation, either plain or guarded by an active-low fault input.

Each mode defines the level the pin takes when the mode is entered. Each mode also defines which event raises the interrupt.

The timer, the register interface and pin multiplexing are outside the block. The surrounding logic presents the count, a period-match strobe, the two compare values and the mode as plain inputs. A change of the mode input is detected internally and counts as a mode write: it re-initialises all pulse and fault state on the next clock edge.

Top module: `oc_unit`

## Requirements
- R1: The mode input is registered and a new value takes effect on the next rising clock edge. The encodings are 000 disabled, 001 falling single-shot, 010 rising single-shot, 011 toggle, 100 delayed pulse, 101 repeating pulse, 110 PWM, 111 PWM with fault guard. After reset the registered mode is 000, the interrupt is 0 and the fault flag is 0.
- R2: While the registered mode is 000, `pin_out` equals `gpio_lvl` and `irq` stays 0.
- R3: Entering mode 001 sets the pin to 1, and the first cycle with `tmr_cnt == cmp_pri` drives it to 0. Entering mode 010 sets the pin to 0, and the first match drives it to 1. Each of these modes pulses `irq` for one cycle on that edge. Later matches change nothing until the mode is rewritten.
- R4: Entering mode 011 keeps the present pin level, including the fallback level when coming from mode 000. Every cycle with `tmr_cnt == cmp_pri` inverts the pin, and `irq` pulses on every inversion.
- R5: Entering mode 100 or 101 sets the pin to 0. The pin rises when `tmr_cnt == cmp_pri` and falls when `tmr_cnt == cmp_sec`, and `irq` pulses only on the falling edge. In mode 100 this happens once per mode write.
- R6: In mode 101 the rise and fall repeat in every timer period.
- R7: Entering mode 110 or 111 sets the pin to 1 if `cmp_pri` is non-zero and to 0 if it is zero. On entry, `cmp_sec` is captured as the active duty value.
- R8: In PWM modes a `prd_hit` cycle captures `cmp_sec` as the active duty and sets the pin to 1, or to 0 if `cmp_sec` is zero. Otherwise, `tmr_cnt` equal to the active duty clears the pin. Mode 110 never raises `irq`.
- R9: In mode 111 a cycle with `flt_n` low forces the pin to 0 on the next edge and sets `flt_flag`. Pin and flag then stay that way while the mode is unchanged. `irq` pulses on each 1-to-0 transition of `flt_n`.
- R10: A mode write clears `flt_flag`. A mode write never raises `irq`, even when the entry level differs from the previous pin level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_cnt | input | 16 | Timer count |
| prd_hit | input | 1 | Timer period-match strobe |
| cmp_pri | input | 16 | Primary compare value |
| cmp_sec | input | 16 | Secondary compare value |
| mode | input | 3 | Mode select |
| gpio_lvl | input | 1 | Fallback pin level used in mode 000 |
| flt_n | input | 1 | Active-low fault input |
| pin_out | output | 1 | Pin level |
| irq | output | 1 | One-cycle interrupt strobe |
| flt_flag | output | 1 | Sticky fault flag |

## Verification
In mode 111, a falling fault input can arrive in the same cycle as a period-match strobe. The strobe wants to drive the pin high, while the fault wants to drive it low and raise the interrupt. The bench freshly enters mode 111 and then applies `flt_n` low together with `prd_hit`. It expects the pin at 0, the flag set and a single interrupt pulse. A second coincidence is a mode write whose entry level differs from the old pin level; here the expected outcome is no interrupt.

// File: rtl/oc_pkg.sv
package oc_pkg;
  typedef enum logic [2:0] {
    OC_OFF  = 3'b000,
    OC_OSL  = 3'b001,
    OC_OSH  = 3'b010,
    OC_TOG  = 3'b011,
    OC_DLY  = 3'b100,
    OC_RPT  = 3'b101,
    OC_PWM  = 3'b110,
    OC_PWMF = 3'b111
  } oc_mode_e;
endpackage

// File: rtl/oc_rst_sync.sv
module oc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = sh_q[STAGES-1];
endmodule

// File: rtl/oc_cmp.sv
module oc_cmp #(
  parameter int W = 16
) (
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] pri,
  input  logic [W-1:0] sec,
  input  logic [W-1:0] duty,
  output logic         eq_pri,
  output logic         eq_sec,
  output logic         eq_duty,
  output logic         pri_nz,
  output logic         sec_nz
);
  assign eq_pri  = (cnt == pri);
  assign eq_sec  = (cnt == sec);
  assign eq_duty = (cnt == duty);
  assign pri_nz  = |pri;
  assign sec_nz  = |sec;
endmodule

// File: rtl/oc_duty.sv
module oc_duty #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] duty_d;

  always_comb begin
    duty_d = q;
    if (load) duty_d = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= duty_d;
  end
endmodule

// File: rtl/oc_core.sv
module oc_core
  import oc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  oc_mode_e mode_i,
  input  logic     prd_hit,
  input  logic     eq_pri,
  input  logic     eq_sec,
  input  logic     eq_duty,
  input  logic     pri_nz,
  input  logic     sec_nz,
  input  logic     gpio_lvl,
  input  logic     flt_i,
  output logic     entry,
  output logic     pin_out,
  output logic     irq,
  output logic     flt_flag
);
  oc_mode_e mode_q;
  logic pin_q, pin_d;
  logic armed_q, armed_d;
  logic flag_d;
  logic flt_q;
  logic irq_d;

  assign entry   = (mode_i != mode_q);
  assign pin_out = (mode_q == OC_OFF) ? gpio_lvl : pin_q;

  always_comb begin
    pin_d   = pin_q;
    armed_d = armed_q;
    flag_d  = flt_flag;
    irq_d   = 1'b0;
    if (entry) begin
      flag_d = 1'b0;
      unique case (mode_i)
        OC_OFF:          pin_d = pin_q;
        OC_OSL:          begin pin_d = 1'b1; armed_d = 1'b1; end
        OC_OSH:          begin pin_d = 1'b0; armed_d = 1'b1; end
        OC_TOG:          pin_d = pin_out;
        OC_DLY, OC_RPT:  begin pin_d = 1'b0; armed_d = 1'b1; end
        OC_PWM, OC_PWMF: pin_d = pri_nz;
        default:         pin_d = pin_q;
      endcase
    end else begin
      unique case (mode_q)
        OC_OSL: if (armed_q && eq_pri) begin pin_d = 1'b0; armed_d = 1'b0; end
        OC_OSH: if (armed_q && eq_pri) begin pin_d = 1'b1; armed_d = 1'b0; end
        OC_TOG: if (eq_pri) pin_d = !pin_q;
        OC_DLY, OC_RPT: begin
          if (armed_q) begin
            if (!pin_q && eq_pri) pin_d = 1'b1;
            else if (pin_q && eq_sec) begin
              pin_d   = 1'b0;
              armed_d = (mode_q == OC_RPT);
            end
          end
        end
        OC_PWM, OC_PWMF: begin
          if (prd_hit)      pin_d = sec_nz;
          else if (eq_duty) pin_d = 1'b0;
          if (mode_q == OC_PWMF) begin
            if (!flt_i) flag_d = 1'b1;
            if (flag_d) pin_d = 1'b0;
          end
        end
        default: pin_d = pin_q;
      endcase
      unique case (mode_q)
        OC_OSL, OC_DLY, OC_RPT: irq_d = pin_q && !pin_d;
        OC_OSH:                 irq_d = !pin_q && pin_d;
        OC_TOG:                 irq_d = pin_q ^ pin_d;
        OC_PWMF:                irq_d = flt_q && !flt_i;
        default:                irq_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= OC_OFF;
      pin_q    <= 1'b0;
      armed_q  <= 1'b0;
      flt_flag <= 1'b0;
      flt_q    <= 1'b1;
      irq      <= 1'b0;
    end else begin
      mode_q   <= mode_i;
      pin_q    <= pin_d;
      armed_q  <= armed_d;
      flt_flag <= flag_d;
      flt_q    <= flt_i;
      irq      <= irq_d;
    end
  end

  // R2: disabled mode stays silent
  a_r2_off_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == OC_OFF && mode_i == OC_OFF) |=> !irq);

  // R5: pulse modes enter with the pin low
  a_r5_entry_low: assert property (@(posedge clk) disable iff (!rst_n)
    (entry && (mode_i == OC_DLY || mode_i == OC_RPT)) |=> !pin_q);

  // R8: plain PWM never interrupts
  a_r8_pwm_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == OC_PWM && mode_i == OC_PWM) |=> !irq);

  // R9: fault forces the pin low and raises the flag
  a_r9_fault_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == OC_PWMF && mode_i == OC_PWMF && !flt_i) |=> (!pin_q && flt_flag));

  // R9: flag is sticky while the mode is unchanged
  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == OC_PWMF && mode_i == OC_PWMF && flt_flag) |=> flt_flag);

  // R10: mode writes clear the flag and never interrupt
  a_r10_entry_clean: assert property (@(posedge clk) disable iff (!rst_n)
    entry |=> (!irq && !flt_flag));
endmodule

// File: rtl/oc_unit.sv
module oc_unit
  import oc_pkg::*;
#(
  parameter int W          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] tmr_cnt,
  input  logic         prd_hit,
  input  logic [W-1:0] cmp_pri,
  input  logic [W-1:0] cmp_sec,
  input  logic [2:0]   mode,
  input  logic         gpio_lvl,
  input  logic         flt_n,
  output logic         pin_out,
  output logic         irq,
  output logic         flt_flag
);
  logic         rst_n_s;
  logic [W-1:0] duty_q;
  logic         eq_pri, eq_sec, eq_duty, pri_nz, sec_nz;
  logic         entry;
  oc_mode_e     mode_e;

  assign mode_e = oc_mode_e'(mode);

  oc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s)
  );

  oc_cmp #(.W(W)) u_cmp (
    .cnt(tmr_cnt), .pri(cmp_pri), .sec(cmp_sec), .duty(duty_q),
    .eq_pri(eq_pri), .eq_sec(eq_sec), .eq_duty(eq_duty),
    .pri_nz(pri_nz), .sec_nz(sec_nz)
  );

  oc_duty #(.W(W)) u_duty (
    .clk(clk), .rst_n(rst_n_s), .load(entry || prd_hit),
    .d(cmp_sec), .q(duty_q)
  );

  oc_core u_core (
    .clk(clk), .rst_n(rst_n_s), .mode_i(mode_e), .prd_hit(prd_hit),
    .eq_pri(eq_pri), .eq_sec(eq_sec), .eq_duty(eq_duty),
    .pri_nz(pri_nz), .sec_nz(sec_nz), .gpio_lvl(gpio_lvl), .flt_i(flt_n),
    .entry(entry), .pin_out(pin_out), .irq(irq), .flt_flag(flt_flag)
  );
endmodule

// File: tb/tb_oc_unit.sv
module tb_oc_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] tmr_cnt = '0;
  logic        prd_hit = 1'b0;
  logic [15:0] cmp_pri = 16'd10;
  logic [15:0] cmp_sec = 16'd20;
  logic [2:0]  mode = 3'b000;
  logic        gpio_lvl = 1'b0;
  logic        flt_n = 1'b1;
  logic        pin_out, irq, flt_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic pin;
    logic irq;
    logic flag;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  oc_unit dut (
    .clk(clk), .rst_n(rst_n), .tmr_cnt(tmr_cnt), .prd_hit(prd_hit),
    .cmp_pri(cmp_pri), .cmp_sec(cmp_sec), .mode(mode), .gpio_lvl(gpio_lvl),
    .flt_n(flt_n), .pin_out(pin_out), .irq(irq), .flt_flag(flt_flag)
  );

  // monitor: compares one expected item per edge, 5 ns after the edge
  always @(posedge clk) begin
    #5;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_chk++;
      if (pin_out !== e.pin || irq !== e.irq || flt_flag !== e.flag) begin
        n_bad++;
        $display("FAIL %s: pin/irq/flag actual %b%b%b expected %b%b%b",
                 e.tag, pin_out, irq, flt_flag, e.pin, e.irq, e.flag);
      end
    end
  end

  task automatic step(input logic [15:0] c, input logic p, input logic [2:0] m,
                      input logic g, input logic f,
                      input logic ep, input logic ei, input logic ef,
                      input string tag);
    exp_t e;
    @(negedge clk);
    tmr_cnt = c; prd_hit = p; mode = m; gpio_lvl = g; flt_n = f;
    @(posedge clk);
    e.pin = ep; e.irq = ei; e.flag = ef; e.tag = tag;
    sb.push_back(e);
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    //   cnt prd mode g  f   pin irq flag
    step(0,  0, 3'd0, 1, 1,  1, 0, 0, "R1 reset state");
    step(0,  0, 3'd0, 0, 1,  0, 0, 0, "R2 pin follows gpio low");
    step(10, 0, 3'd0, 0, 1,  0, 0, 0, "R2 no irq on match");
    step(10, 0, 3'd0, 1, 1,  1, 0, 0, "R2 pin follows gpio high");
    // rising single-shot
    step(0,  0, 3'd2, 0, 1,  0, 0, 0, "R3 osh entry low");
    step(5,  0, 3'd2, 0, 1,  0, 0, 0, "R3 osh wait");
    step(10, 0, 3'd2, 0, 1,  1, 1, 0, "R3 osh rise irq");
    step(11, 0, 3'd2, 0, 1,  1, 0, 0, "R3 osh hold");
    step(10, 0, 3'd2, 0, 1,  1, 0, 0, "R3 osh once");
    // falling single-shot
    step(0,  0, 3'd1, 0, 1,  1, 0, 0, "R3 osl entry high");
    step(10, 0, 3'd1, 0, 1,  0, 1, 0, "R3 osl fall irq");
    step(10, 0, 3'd1, 0, 1,  0, 0, 0, "R3 osl once");
    // toggle
    step(0,  0, 3'd3, 0, 1,  0, 0, 0, "R4 tog keeps level");
    step(10, 0, 3'd3, 0, 1,  1, 1, 0, "R4 tog rise irq");
    step(11, 0, 3'd3, 0, 1,  1, 0, 0, "R4 tog hold");
    step(10, 0, 3'd3, 0, 1,  0, 1, 0, "R4 tog fall irq");
    step(0,  0, 3'd0, 1, 1,  1, 0, 0, "R2 back to gpio");
    step(0,  0, 3'd3, 1, 1,  1, 0, 0, "R4 tog keeps gpio level");
    step(10, 0, 3'd3, 1, 1,  0, 1, 0, "R4 tog from gpio level");
    // delayed pulse
    step(0,  0, 3'd4, 0, 1,  0, 0, 0, "R5 dly entry low");
    step(10, 0, 3'd4, 0, 1,  1, 0, 0, "R5 dly rise no irq");
    step(15, 0, 3'd4, 0, 1,  1, 0, 0, "R5 dly hold");
    step(20, 0, 3'd4, 0, 1,  0, 1, 0, "R5 dly fall irq");
    step(10, 0, 3'd4, 0, 1,  0, 0, 0, "R5 dly once");
    step(20, 0, 3'd4, 0, 1,  0, 0, 0, "R5 dly stays idle");
    // repeating pulse
    step(0,  0, 3'd5, 0, 1,  0, 0, 0, "R5 rpt entry low");
    step(10, 0, 3'd5, 0, 1,  1, 0, 0, "R6 rpt rise");
    step(20, 0, 3'd5, 0, 1,  0, 1, 0, "R6 rpt fall irq");
    step(0,  1, 3'd5, 0, 1,  0, 0, 0, "R6 rpt new period");
    step(10, 0, 3'd5, 0, 1,  1, 0, 0, "R6 rpt rise again");
    step(20, 0, 3'd5, 0, 1,  0, 1, 0, "R6 rpt fall again");
    // plain PWM, duty 5
    @(negedge clk) cmp_sec = 16'd5;
    step(0,  0, 3'd6, 0, 1,  1, 0, 0, "R7 pwm entry high");
    step(5,  0, 3'd6, 0, 1,  0, 0, 0, "R8 duty match low");
    step(7,  0, 3'd6, 0, 1,  0, 0, 0, "R8 stays low");
    step(30, 1, 3'd6, 0, 1,  1, 0, 0, "R8 period start high");
    step(3,  0, 3'd6, 0, 1,  1, 0, 0, "R8 high before duty");
    step(5,  0, 3'd6, 0, 1,  0, 0, 0, "R8 low no irq");
    @(negedge clk) cmp_sec = 16'd0;
    step(30, 1, 3'd6, 0, 1,  0, 0, 0, "R8 zero duty stays low");
    step(0,  0, 3'd6, 0, 1,  0, 0, 0, "R8 zero duty low");
    @(negedge clk) cmp_pri = 16'd0;
    step(0,  0, 3'd0, 0, 1,  0, 0, 0, "R2 off");
    step(0,  0, 3'd6, 0, 1,  0, 0, 0, "R7 pwm entry zero primary");
    @(negedge clk) begin cmp_pri = 16'd10; cmp_sec = 16'd8; end
    // guarded PWM
    step(0,  0, 3'd7, 0, 1,  1, 0, 0, "R7 pwmf entry high");
    step(8,  0, 3'd7, 0, 1,  0, 0, 0, "R8 pwmf duty low");
    step(30, 1, 3'd7, 0, 1,  1, 0, 0, "R8 pwmf period high");
    step(2,  0, 3'd7, 0, 0,  0, 1, 1, "R9 fault low irq flag");
    step(3,  0, 3'd7, 0, 0,  0, 0, 1, "R9 fault held no new irq");
    step(4,  0, 3'd7, 0, 1,  0, 0, 1, "R9 flag sticky");
    step(30, 1, 3'd7, 0, 1,  0, 0, 1, "R9 pin held low at period");
    step(0,  0, 3'd6, 0, 1,  1, 0, 0, "R10 mode write clears flag");
    step(0,  0, 3'd7, 0, 1,  1, 0, 0, "R10 re-entry no irq");
    step(30, 1, 3'd7, 0, 0,  0, 1, 1, "R9 fault beats period strobe");
    step(0,  0, 3'd1, 0, 1,  1, 0, 0, "R10 entry edge no irq");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule